// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Dispatcher

This block sits beside a processor core's fetch logic. It decides whether the interrupt level presented by an external prioritizer is accepted, and it applies the resulting state change to the processor in a single clock edge. When the core samples the block with a one-cycle `poll` strobe, the block checks three things: the offered level is above the interrupt level held in the status word, it is within the configured number of levels, and at least one source belonging to that level is both pending and enabled.

An accepted level above one is handled as a direct vectored interrupt, and the state it interrupts is saved into a register bank for that level. An accepted level of one becomes a general exception instead. For it the block records a fixed cause code and classifies the exception as kernel, user or double from the mode bits of the status word. Every vector address is a fixed offset from either a build-time base or a programmable base register.

The core loads `newPc` whenever `pcLoad` is high. It writes the status word and the vector base through plain write strobes.

Top module: `irq_dispatch`

## Requirements
- R1: A poll is accepted only if `pendLevel` > status[3:0], `pendLevel` <= NUM_LEVELS, and the mask slice of that level (bits `(L-1)*NUM_INTS` upward in `levelMask`) ANDed with `intPending` and `intEnable` is nonzero. A cycle with `poll` low, or a rejected poll, leaves every output unchanged and keeps `pcLoad` low.
- R2: An accepted level L > 1 stores `curPc` into slot L-1 of `savedPcFlat` and the previous status word into slot L-1 of `savedPsFlat`. Each slot is 32 and 8 bits wide respectively, and no other slot changes.
- R3: An accepted level L > 1 sets status[3:0] to L and sets status bit 4 (exception mode). Bit 5 (user mode) keeps its value.
- R4: An accepted level 1 writes cause code 4 to `cause` and sets status bit 4. It does not change status[3:0].
- R5: `excClass` is encoded as 0 (vectored, level above one), 1 (kernel), 2 (user) and 3 (double). A level-1 take with status bit 4 clear stores `curPc` into slot 0 of `savedPcFlat` and reports user when status bit 5 is set, kernel otherwise.
- R6: A level-1 take with status bit 4 already set reports a double exception. It stores `curPc` into `depc` when HAS_DEPC is 1, and into slot 0 of `savedPcFlat` otherwise.
- R7: Vector offsets are 0x100 + L*0x40 for level L > 1, 0x300 for kernel, 0x340 for user and 0x3C0 for double. With RELOC_EN = 1 the vector is DEFAULT_VECBASE + offset - DEFAULT_VECBASE + `vecBase`. With RELOC_EN = 0 it is DEFAULT_VECBASE + offset, and writes to `vecBase` have no effect on it.
- R8: Reset sets status to 0x1F when INT_OPT is 1 and to 0x10 when it is 0. It loads `vecBase` with DEFAULT_VECBASE and clears `pcLoad`, `cause`, `excClass`, `depc` and all saved slots.
- R9: `pcLoad` is high for exactly the one cycle after the edge at which a poll is accepted, and `newPc` holds the vector in that cycle.
- R10: `psWrEn` loads `psWrData` into the status word. When an accepted poll falls in the same cycle, the dispatch update wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| poll | input | 1 | One-cycle request to evaluate the offered level |
| pendLevel | input | 4 | Highest pending interrupt level from the prioritizer |
| curPc | input | 32 | PC to save if the interrupt is taken |
| intPending | input | NUM_INTS | Pending interrupt sources |
| intEnable | input | NUM_INTS | Enabled interrupt sources |
| levelMask | input | NUM_LEVELS*NUM_INTS | Source mask per level, level L in slice L-1 |
| psWrEn | input | 1 | Status word write strobe |
| psWrData | input | 8 | Status word write value |
| vbWrEn | input | 1 | Vector base write strobe |
| vbWrData | input | 32 | Vector base write value |
| pcLoad | output | 1 | Taken pulse; core loads newPc |
| newPc | output | 32 | Vector address of the last dispatch |
| status | output | 8 | Status word: [3:0] level, 4 exception mode, 5 user mode |
| cause | output | 6 | Exception cause register |
| excClass | output | 2 | Class of the last dispatch |
| savedPcFlat | output | NUM_LEVELS*32 | Saved PC per level |
| savedPsFlat | output | NUM_LEVELS*8 | Saved status per level (slot 0 unused) |
| depc | output | 32 | Double-exception saved PC |
| vecBase | output | 32 | Programmable vector base |

## Verification
The assertions take for granted that `pendLevel` fits the 4-bit status level field, that NUM_LEVELS is at most 7 so that the level vectors stay below the level-1 exception vectors, and that `poll` is a single-cycle strobe. They do not assume that `psWrEn` and `poll` are kept apart, because R10 defines what happens when both are high. The stimulus writes the status word before each poll and drives all inputs on the falling edge, so every poll sees a settled status word. Levels beyond NUM_LEVELS are offered only through `pendLevel`, never through the mask table. A second instance with no double-exception register, no relocation and no interrupt option shares the same inputs and is checked at the points where its variant behaves differently.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

  localparam int PS_W = 8;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT = 5;
  localparam logic [5:0] LVL1_CAUSE = 6'd4;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_KERNEL = 2'd1,
    CLS_USER   = 2'd2,
    CLS_DOUBLE = 2'd3
  } excClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       takeHigh;
    logic       takeLow;
    logic       lowDouble;
    logic       lowUser;
    logic [3:0] level;
  } dispStrobe_t;

  // offset of a vector from the base
  function automatic logic [31:0] vecOffset(input logic isLow, input excClass_e cls,
                                            input logic [3:0] lvl);
    if (!isLow) return 32'h100 + {22'b0, lvl, 6'b0};
    case (cls)
      CLS_USER:   return 32'h340;
      CLS_DOUBLE: return 32'h3C0;
      default:    return 32'h300;
    endcase
  endfunction

endpackage

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_LEVELS = 6,
  parameter int NUM_INTS   = 8
) (
  input  logic                         poll,
  input  logic [3:0]                   pendLevel,
  input  logic [3:0]                   curLevel,
  input  logic                         excMode,
  input  logic                         userMode,
  input  logic [NUM_INTS-1:0]          intPending,
  input  logic [NUM_INTS-1:0]          intEnable,
  input  logic [NUM_LEVELS*NUM_INTS-1:0] levelMask,
  output dispStrobe_t                  strb
);

  logic [NUM_INTS-1:0] maskArr [1:NUM_LEVELS];
  logic [NUM_INTS-1:0] selMask;
  logic                levelOk;
  logic                take;

  for (genvar g = 1; g <= NUM_LEVELS; g++) begin : gSlice
    assign maskArr[g] = levelMask[(g-1)*NUM_INTS +: NUM_INTS];
  end

  always_comb begin
    selMask = '0;
    for (int i = 1; i <= NUM_LEVELS; i++) begin
      if (pendLevel == 4'(i)) selMask = maskArr[i];
    end
  end

  assign levelOk = (pendLevel > curLevel) && (pendLevel <= 4'(NUM_LEVELS));
  assign take    = poll && levelOk && |(selMask & intPending & intEnable);

  always_comb begin
    strb.takeHigh  = take && (pendLevel > 4'd1);
    strb.takeLow   = take && (pendLevel == 4'd1);
    strb.lowDouble = excMode;
    strb.lowUser   = userMode;
    strb.level     = pendLevel;
  end

endmodule

// File: rtl/irq_dispatch_datapath.sv
module irq_dispatch_datapath
  import irq_dispatch_pkg::*;
#(
  parameter int          NUM_LEVELS      = 6,
  parameter bit          HAS_DEPC        = 1'b1,
  parameter bit          RELOC_EN        = 1'b1,
  parameter bit          INT_OPT         = 1'b1,
  parameter logic [31:0] DEFAULT_VECBASE = 32'h4000_0000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dispStrobe_t              strb,
  input  logic [31:0]              curPc,
  input  logic                     psWrEn,
  input  logic [PS_W-1:0]          psWrData,
  input  logic                     vbWrEn,
  input  logic [31:0]              vbWrData,
  output logic                     pcLoad,
  output logic [31:0]              newPc,
  output logic [PS_W-1:0]          status,
  output logic [5:0]               cause,
  output logic [1:0]               excClass,
  output logic [NUM_LEVELS*32-1:0] savedPcFlat,
  output logic [NUM_LEVELS*8-1:0]  savedPsFlat,
  output logic [31:0]              depc,
  output logic [31:0]              vecBase
);

  localparam logic [PS_W-1:0] PS_RESET = INT_OPT ? 8'h1F : 8'h10;

  logic [31:0]     savedPc [1:NUM_LEVELS];
  logic [PS_W-1:0] savedPs [1:NUM_LEVELS];
  excClass_e       clsQ;
  excClass_e       lowCls;
  logic [31:0]     vecOff;
  logic [31:0]     vecAddr;

  for (genvar g = 1; g <= NUM_LEVELS; g++) begin : gFlat
    assign savedPcFlat[(g-1)*32 +: 32] = savedPc[g];
    assign savedPsFlat[(g-1)*8 +: 8]   = savedPs[g];
  end

  assign lowCls = strb.lowDouble ? CLS_DOUBLE : (strb.lowUser ? CLS_USER : CLS_KERNEL);
  assign vecOff = vecOffset(strb.takeLow, lowCls, strb.level);

  if (RELOC_EN) begin : gReloc
    assign vecAddr = DEFAULT_VECBASE + vecOff - DEFAULT_VECBASE + vecBase;
  end else begin : gFixed
    assign vecAddr = DEFAULT_VECBASE + vecOff;
  end

  assign excClass = clsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcLoad  <= 1'b0;
      newPc   <= '0;
      status  <= PS_RESET;
      cause   <= '0;
      clsQ    <= CLS_NONE;
      depc    <= '0;
      vecBase <= DEFAULT_VECBASE;
      for (int i = 1; i <= NUM_LEVELS; i++) begin
        savedPc[i] <= '0;
        savedPs[i] <= '0;
      end
    end else begin
      pcLoad <= strb.takeHigh | strb.takeLow;
      if (vbWrEn) vecBase <= vbWrData;
      if (strb.takeHigh) begin
        for (int i = 2; i <= NUM_LEVELS; i++) begin
          if (strb.level == 4'(i)) begin
            savedPc[i] <= curPc;
            savedPs[i] <= status;
          end
        end
        status[3:0]         <= strb.level;
        status[PS_EXCM_BIT] <= 1'b1;
        clsQ                <= CLS_NONE;
        newPc               <= vecAddr;
      end else if (strb.takeLow) begin
        cause <= LVL1_CAUSE;
        if (strb.lowDouble && HAS_DEPC) depc <= curPc;
        else                            savedPc[1] <= curPc;
        status[PS_EXCM_BIT] <= 1'b1;
        clsQ                <= lowCls;
        newPc               <= vecAddr;
      end else if (psWrEn) begin
        status <= psWrData;
      end
    end
  end

  // R4: a level-one dispatch leaves the cause code and exception mode
  a_r4_low_cause: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && excClass != 2'(CLS_NONE)) |-> (cause == LVL1_CAUSE && status[PS_EXCM_BIT]));

  // R3: a vectored dispatch raises the level field and sets exception mode
  a_r3_level_raised: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && excClass == 2'(CLS_NONE)) |->
      (status[PS_EXCM_BIT] && status[3:0] > $past(status[3:0])));

  // R1: a vectored level never exceeds the configured count
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && excClass == 2'(CLS_NONE)) |-> (status[3:0] <= 4'(NUM_LEVELS)));

  // R6: a double exception captures the interrupted PC
  a_r6_double_pc: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && excClass == 2'(CLS_DOUBLE) && HAS_DEPC) |-> (depc == $past(curPc)));

  // R7: the vector lies inside the window above the base in use
  a_r7_vector_window: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> ((newPc - (RELOC_EN ? $past(vecBase) : DEFAULT_VECBASE)) < 32'h400));

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int          NUM_LEVELS      = 6,
  parameter int          NUM_INTS        = 8,
  parameter bit          HAS_DEPC        = 1'b1,
  parameter bit          RELOC_EN        = 1'b1,
  parameter bit          INT_OPT         = 1'b1,
  parameter logic [31:0] DEFAULT_VECBASE = 32'h4000_0000
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           poll,
  input  logic [3:0]                     pendLevel,
  input  logic [31:0]                    curPc,
  input  logic [NUM_INTS-1:0]            intPending,
  input  logic [NUM_INTS-1:0]            intEnable,
  input  logic [NUM_LEVELS*NUM_INTS-1:0] levelMask,
  input  logic                           psWrEn,
  input  logic [7:0]                     psWrData,
  input  logic                           vbWrEn,
  input  logic [31:0]                    vbWrData,
  output logic                           pcLoad,
  output logic [31:0]                    newPc,
  output logic [7:0]                     status,
  output logic [5:0]                     cause,
  output logic [1:0]                     excClass,
  output logic [NUM_LEVELS*32-1:0]       savedPcFlat,
  output logic [NUM_LEVELS*8-1:0]        savedPsFlat,
  output logic [31:0]                    depc,
  output logic [31:0]                    vecBase
);

  dispStrobe_t strb;

  irq_dispatch_ctrl #(
    .NUM_LEVELS(NUM_LEVELS),
    .NUM_INTS  (NUM_INTS)
  ) uCtrl (
    .poll      (poll),
    .pendLevel (pendLevel),
    .curLevel  (status[3:0]),
    .excMode   (status[PS_EXCM_BIT]),
    .userMode  (status[PS_UM_BIT]),
    .intPending(intPending),
    .intEnable (intEnable),
    .levelMask (levelMask),
    .strb      (strb)
  );

  irq_dispatch_datapath #(
    .NUM_LEVELS     (NUM_LEVELS),
    .HAS_DEPC       (HAS_DEPC),
    .RELOC_EN       (RELOC_EN),
    .INT_OPT        (INT_OPT),
    .DEFAULT_VECBASE(DEFAULT_VECBASE)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .curPc      (curPc),
    .psWrEn     (psWrEn),
    .psWrData   (psWrData),
    .vbWrEn     (vbWrEn),
    .vbWrData   (vbWrData),
    .pcLoad     (pcLoad),
    .newPc      (newPc),
    .status     (status),
    .cause      (cause),
    .excClass   (excClass),
    .savedPcFlat(savedPcFlat),
    .savedPsFlat(savedPsFlat),
    .depc       (depc),
    .vecBase    (vecBase)
  );

  // R9: a taken pulse only follows a poll
  a_r9_take_needs_poll: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> $past(poll));

endmodule

// File: tb/sim_irq_dispatch.sv
module sim_irq_dispatch;

  localparam int NL = 6;
  localparam int NI = 8;
  localparam logic [31:0] DEFVB = 32'h4000_0000;
  localparam logic [NL*NI-1:0] LMASK = {8'hC0, 8'h20, 8'h10, 8'h08, 8'h04, 8'h03};

  typedef struct packed {
    logic [7:0]  ps;
    logic [3:0]  lvl;
    logic [7:0]  pend;
    logic [7:0]  en;
    logic [31:0] pc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 4'd3, 8'h08, 8'h08, 32'h0000_1000},  // high level taken
    '{8'h03, 4'd3, 8'h08, 8'h08, 32'h0000_1004},  // not above current
    '{8'h00, 4'd7, 8'hFF, 8'hFF, 32'h0000_1008},  // beyond level count
    '{8'h00, 4'd2, 8'h04, 8'h00, 32'h0000_100C},  // disabled
    '{8'h00, 4'd2, 8'h08, 8'h08, 32'h0000_1010},  // wrong mask
    '{8'h00, 4'd1, 8'h01, 8'h01, 32'h0000_2000},  // kernel
    '{8'h20, 4'd1, 8'h02, 8'h02, 32'h0000_2004},  // user
    '{8'h10, 4'd1, 8'h01, 8'h01, 32'h0000_2008},  // double
    '{8'h22, 4'd6, 8'h80, 8'h80, 32'h0000_3000},  // high from user mode
    '{8'h05, 4'd6, 8'h40, 8'h40, 32'h0000_3004}   // high above level 5
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic poll = 1'b0;
  logic [3:0] pendLevel = '0;
  logic [31:0] curPc = '0;
  logic [NI-1:0] intPending = '0;
  logic [NI-1:0] intEnable = '0;
  logic psWrEn = 1'b0;
  logic [7:0] psWrData = '0;
  logic vbWrEn = 1'b0;
  logic [31:0] vbWrData = '0;

  logic pcLoad, u1PcLoad;
  logic [31:0] newPc, u1NewPc, depc, u1Depc, vecBase, u1VecBase;
  logic [7:0] status, u1Status;
  logic [5:0] cause, u1Cause;
  logic [1:0] excClass, u1ExcClass;
  logic [NL*32-1:0] savedPcFlat, u1SavedPcFlat;
  logic [NL*8-1:0] savedPsFlat, u1SavedPsFlat;

  always #2 clk = ~clk;

  irq_dispatch u0 (
    .clk(clk), .rstN(rstN), .poll(poll), .pendLevel(pendLevel), .curPc(curPc),
    .intPending(intPending), .intEnable(intEnable), .levelMask(LMASK),
    .psWrEn(psWrEn), .psWrData(psWrData), .vbWrEn(vbWrEn), .vbWrData(vbWrData),
    .pcLoad(pcLoad), .newPc(newPc), .status(status), .cause(cause),
    .excClass(excClass), .savedPcFlat(savedPcFlat), .savedPsFlat(savedPsFlat),
    .depc(depc), .vecBase(vecBase)
  );

  irq_dispatch #(.HAS_DEPC(1'b0), .RELOC_EN(1'b0), .INT_OPT(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .poll(poll), .pendLevel(pendLevel), .curPc(curPc),
    .intPending(intPending), .intEnable(intEnable), .levelMask(LMASK),
    .psWrEn(psWrEn), .psWrData(psWrData), .vbWrEn(vbWrEn), .vbWrData(vbWrData),
    .pcLoad(u1PcLoad), .newPc(u1NewPc), .status(u1Status), .cause(u1Cause),
    .excClass(u1ExcClass), .savedPcFlat(u1SavedPcFlat), .savedPsFlat(u1SavedPsFlat),
    .depc(u1Depc), .vecBase(u1VecBase)
  );

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // reference state for u0
  logic [7:0] mStatus = 8'h1F;
  logic [31:0] mVecBase = DEFVB;
  logic [31:0] mNewPc = '0;
  logic [5:0] mCause = '0;
  logic [1:0] mClass = '0;
  logic [31:0] mDepc = '0;
  logic [NL*32-1:0] mSavedPc = '0;
  logic [NL*8-1:0] mSavedPs = '0;
  logic mLoad = 1'b0;

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  function automatic logic [7:0] maskOf(input int lvl);
    if (lvl >= 1 && lvl <= NL) return LMASK[(lvl-1)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic modelStep(input int lvl, input logic [7:0] pend, input logic [7:0] en,
                           input logic [31:0] pc);
    logic [31:0] off;
    mLoad = (lvl > int'(mStatus[3:0])) && (lvl <= NL) && ((maskOf(lvl) & pend & en) != 0);
    if (mLoad) begin
      if (lvl > 1) begin
        mSavedPc[(lvl-1)*32 +: 32] = pc;
        mSavedPs[(lvl-1)*8 +: 8] = mStatus;
        mStatus[3:0] = 4'(lvl);
        mStatus[4] = 1'b1;
        mClass = 2'd0;
        off = 32'h100 + 32'(lvl) * 32'h40;
      end else begin
        mCause = 6'd4;
        if (mStatus[4]) begin
          mDepc = pc; mClass = 2'd3; off = 32'h3C0;
        end else begin
          mSavedPc[31:0] = pc;
          mClass = mStatus[5] ? 2'd2 : 2'd1;
          off = mStatus[5] ? 32'h340 : 32'h300;
        end
        mStatus[4] = 1'b1;
      end
      mNewPc = mVecBase + off;
    end
  endtask

  task automatic checkAll();
    chk("R1", pcLoad, mLoad);
    chk("R3", status, mStatus);
    chk("R7", newPc, mNewPc);
    chk("R4", cause, mCause);
    chk("R5", excClass, mClass);
    chk("R6", depc, mDepc);
    chk("R2", savedPcFlat, mSavedPc);
    chk("R2", savedPsFlat, mSavedPs);
  endtask

  task automatic writePs(input logic [7:0] v);
    @(negedge clk); psWrEn = 1'b1; psWrData = v;
    @(negedge clk); psWrEn = 1'b0;
    mStatus = v;
  endtask

  task automatic dispatch(input logic [3:0] lvl, input logic [7:0] pend, input logic [7:0] en,
                          input logic [31:0] pc);
    @(negedge clk); poll = 1'b1; pendLevel = lvl; intPending = pend; intEnable = en; curPc = pc;
    @(negedge clk); poll = 1'b0;
    modelStep(int'(lvl), pend, en, pc);
    checkAll();
    @(negedge clk);
    chk("R9", pcLoad, 1'b0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8: reset values
    chk("R8", status, 8'h1F);
    chk("R8", vecBase, DEFVB);
    chk("R8", pcLoad, 1'b0);
    chk("R8", cause, 6'd0);
    chk("R8", savedPcFlat, '0);
    chk("R8", u1Status, 8'h10);

    // R1: reset level field blocks all levels
    dispatch(4'd6, 8'h80, 8'h80, 32'h0000_0F00);

    // R1: poll low has no effect even with a valid request
    @(negedge clk); pendLevel = 4'd6; intPending = 8'hFF; intEnable = 8'hFF;
    writePs(8'h00);
    chk("R10", status, 8'h00);
    @(negedge clk); @(negedge clk);
    chk("R1", pcLoad, 1'b0);
    chk("R1", status, 8'h00);

    for (int i = 0; i < NV; i++) begin
      writePs(VECS[i].ps);
      dispatch(VECS[i].lvl, VECS[i].pend, VECS[i].en, VECS[i].pc);
    end

    // R7: relocated base
    @(negedge clk); vbWrEn = 1'b1; vbWrData = 32'h8000_0000;
    @(negedge clk); vbWrEn = 1'b0; mVecBase = 32'h8000_0000;
    chk("R7", vecBase, 32'h8000_0000);
    writePs(8'h00);
    dispatch(4'd2, 8'h04, 8'h04, 32'h0000_4000);
    chk("R7", newPc, 32'h8000_0180);
    chk("R7", u1NewPc, DEFVB + 32'h180);

    // R10: dispatch wins over a status write in the same cycle
    writePs(8'h00);
    @(negedge clk); poll = 1'b1; pendLevel = 4'd2; intPending = 8'h04; intEnable = 8'h04;
    curPc = 32'h0000_5000; psWrEn = 1'b1; psWrData = 8'h07;
    @(negedge clk); poll = 1'b0; psWrEn = 1'b0;
    modelStep(2, 8'h04, 8'h04, 32'h0000_5000);
    chk("R10", status, 8'h12);
    chk("R9", pcLoad, 1'b1);
    checkAll();

    // R6: double without a dedicated register saves into slot 0
    writePs(8'h10);
    dispatch(4'd1, 8'h01, 8'h01, 32'hABCD_0000);
    chk("R6", u1SavedPcFlat[31:0], 32'hABCD_0000);
    chk("R6", u1Depc, 32'h0);
    chk("R6", u1NewPc, DEFVB + 32'h3C0);
    chk("R6", depc, 32'hABCD_0000);

    done = 1'b1;
    finishRun();
  end

endmodule